// File: doc/BRIEF.md
# Host Command and Reply Queue Ports

This block is the register front end that a storage controller shows to its host. The host hands over work by writing 32-bit command-list bus addresses into a request queue. It collects finished work by reading 32-bit completion tags from a reply queue. On the controller side, the request queue is drained through a valid/ready pop port and the reply queue is filled through a valid/ready push port.

Several conventions are inverted compared with a plain FIFO register. Reading the request port reports occupancy: zero means there is room. Reading the reply port only peeks at the head entry, and an empty queue reads as all-ones. The host removes the head by writing zero to the same port. The interrupt mask is a disable bit, so interrupts are enabled while the mask register holds zero. The pending bit sits in a separate status word, and it tracks only whether a reply is waiting.

Top module: `hqp_top`

## Requirements
- R1: A host write to word address 0 (request port) appends the written value to the request queue. The controller receives the entries in write order on `req_data` while `req_valid` is high; an entry leaves the queue on a cycle with `req_valid` and `req_ready` both high. While it is not taken, `req_data` holds steady.
- R2: A host read of word address 0 returns 0 while the request queue has room and 1 while it holds `REQ_DEPTH` entries.
- R3: A host write to the request port while the queue is full is dropped. This holds even if the controller pops in the same cycle. The drop sets a sticky overflow flag, bit 1 of the status word (word address 3), which stays set until reset.
- R4: A host read of word address 1 (reply port) returns 0xFFFFFFFF while the reply queue is empty. Otherwise it returns the head entry without removing it, so repeated reads return the same value.
- R5: A host write of zero to the reply port removes the head entry. A nonzero write to that port is ignored, and so is a zero write while the queue is empty.
- R6: `rpl_ready` is high exactly while the reply queue has fewer than `RPL_DEPTH` entries. A push on `rpl_valid` and `rpl_ready` appends `rpl_data`, and the host reads the entries back in push order.
- R7: Bit 3 of word address 2 is an interrupt disable. Writing 0x08 sets it and writing 0 clears it, and a read returns the bit in place. While it is set, `irq` is low.
- R8: Status bit 0 is 1 exactly while the reply queue is non-empty, whatever the mask. `irq` equals that bit while the disable bit is clear.
- R9: After reset, both queues are empty, the mask word reads 0x08, the status word reads 0, and `irq` is low.
- R10: A push and a pop on the same queue in one cycle both take effect. This covers a host write plus a controller pop on the request side, and a controller push plus a host zero write on the reply side. The occupancy stays the same and order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 request, 1 reply, 2 mask, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| req_valid | output | 1 | Request queue holds an entry |
| req_ready | input | 1 | Controller takes the head request |
| req_data | output | 32 | Head request (command-list address) |
| rpl_valid | input | 1 | Controller offers a completion tag |
| rpl_ready | output | 1 | Reply queue has room |
| rpl_data | input | 32 | Completion tag |
| irq | output | 1 | Interrupt to the host |

## Verification
Each queue can be pushed and popped in the same cycle by the two different sides, and those collisions are the main concern. The bench provokes them directly. On the reply queue, it drives `rpl_valid` together with a host zero write. On the request queue, it drives a host write together with `req_ready`, once with room and once while the queue is full. The scoreboards judge the result by entry order: the popped value must be the old head and the new value must appear at the tail. In the full case, the dropped value must never reach the controller, and the overflow bit must be set.

// File: rtl/hqp_pkg.sv
package hqp_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_REQ  = 2'd0,
        REG_RPL  = 2'd1,
        REG_MASK = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    localparam int MASK_DIS_BIT = 3;
    localparam int STAT_PEND_BIT = 0;
    localparam int STAT_OVF_BIT = 1;

endpackage

// File: rtl/hqp_fifo.sv
module hqp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);
    assign head  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hqp_irq_ctrl.sv
module hqp_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_we,
    input  logic mask_wbit,
    input  logic ovf_set,
    input  logic reply_nonempty,
    output logic mask_dis,
    output logic ovf_flag,
    output logic pending,
    output logic irq
);
    typedef struct packed {
        logic dis;
        logic ovf;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.dis = mask_wbit;
        end
        if (ovf_set) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{dis: 1'b1, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_dis = st_q.dis;
    assign ovf_flag = st_q.ovf;
    assign pending  = reply_nonempty;
    assign irq      = reply_nonempty && !st_q.dis;

endmodule

// File: rtl/hqp_bus_dec.sv
module hqp_bus_dec
    import hqp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              req_full,
    input  logic              rpl_empty,
    input  logic [DATA_W-1:0] rpl_head,
    input  logic              mask_dis,
    input  logic              pending,
    input  logic              ovf_flag,
    output logic              req_push,
    output logic              rpl_pop,
    output logic              mask_we,
    output logic              mask_wbit,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;
    logic     wr_stb, rd_stb;

    assign sel    = reg_sel_e'(bus_addr);
    assign wr_stb = bus_sel && bus_wr;
    assign rd_stb = bus_sel && !bus_wr;

    always_comb begin
        req_push  = 1'b0;
        rpl_pop   = 1'b0;
        mask_we   = 1'b0;
        mask_wbit = bus_wdata[MASK_DIS_BIT];
        if (wr_stb) begin
            case (sel)
                REG_REQ:  req_push = 1'b1;
                REG_RPL:  rpl_pop  = (bus_wdata == '0);
                REG_MASK: mask_we  = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (sel)
                REG_REQ:  bus_rdata = DATA_W'(req_full);
                REG_RPL:  bus_rdata = rpl_empty ? '1 : rpl_head;
                REG_MASK: bus_rdata[MASK_DIS_BIT] = mask_dis;
                REG_STAT: begin
                    bus_rdata[STAT_PEND_BIT] = pending;
                    bus_rdata[STAT_OVF_BIT]  = ovf_flag;
                end
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/hqp_top.sv
module hqp_top
    import hqp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REQ_DEPTH = 16,
    parameter int RPL_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [DATA_W-1:0] req_data,
    input  logic              rpl_valid,
    output logic              rpl_ready,
    input  logic [DATA_W-1:0] rpl_data,
    output logic              irq
);
    logic              req_push, req_empty, req_full;
    logic              rpl_pop, rpl_empty, rpl_full;
    logic [DATA_W-1:0] rpl_head;
    logic              mask_we, mask_wbit, mask_dis, ovf_flag, pending;

    hqp_bus_dec #(.DATA_W(DATA_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req_full  (req_full),
        .rpl_empty (rpl_empty),
        .rpl_head  (rpl_head),
        .mask_dis  (mask_dis),
        .pending   (pending),
        .ovf_flag  (ovf_flag),
        .req_push  (req_push),
        .rpl_pop   (rpl_pop),
        .mask_we   (mask_we),
        .mask_wbit (mask_wbit),
        .bus_rdata (bus_rdata)
    );

    hqp_fifo #(.WIDTH(DATA_W), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_push),
        .push_data (bus_wdata),
        .pop       (req_ready),
        .head      (req_data),
        .empty     (req_empty),
        .full      (req_full)
    );

    hqp_fifo #(.WIDTH(DATA_W), .DEPTH(RPL_DEPTH)) u_rpl_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rpl_valid),
        .push_data (rpl_data),
        .pop       (rpl_pop),
        .head      (rpl_head),
        .empty     (rpl_empty),
        .full      (rpl_full)
    );

    hqp_irq_ctrl u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .mask_we        (mask_we),
        .mask_wbit      (mask_wbit),
        .ovf_set        (req_push && req_full),
        .reply_nonempty (!rpl_empty),
        .mask_dis       (mask_dis),
        .ovf_flag       (ovf_flag),
        .pending        (pending),
        .irq            (irq)
    );

    assign req_valid = !req_empty;
    assign rpl_ready = !rpl_full;

endmodule

// File: rtl/hqp_chk.sv
module hqp_chk
    import hqp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] req_data,
    input logic              rpl_valid,
    input logic              irq,
    input logic              mask_dis,
    input logic              ovf_flag,
    input logic              rpl_empty,
    input logic [DATA_W-1:0] rpl_head
);
    // R1: an offered request that is not taken stays offered and unchanged
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_data));

    // R3: overflow flag never clears without reset
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R4: empty reply queue reads as all-ones
    p_empty_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr == REG_RPL && rpl_empty |-> bus_rdata == '1);

    // R5: a nonzero write to the reply port leaves the head in place
    p_nonzero_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == REG_RPL && bus_wdata != '0 && !rpl_empty
        |=> !rpl_empty && $stable(rpl_head));

    // R7: disable bit keeps the interrupt low
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_dis |-> !irq);

    // R8: interrupt only while a reply waits
    p_irq_needs_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !rpl_empty);

    // R6: an offered reply into an empty queue makes it non-empty
    p_push_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_valid && rpl_empty |=> !rpl_empty);

endmodule

bind hqp_top hqp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_data  (req_data),
    .rpl_valid (rpl_valid),
    .irq       (irq),
    .mask_dis  (mask_dis),
    .ovf_flag  (ovf_flag),
    .rpl_empty (rpl_empty),
    .rpl_head  (rpl_head)
);

// File: tb/tb_hqp_top.sv
module tb_hqp_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [DW-1:0] req_data;
    logic          rpl_valid = 1'b0;
    logic          rpl_ready;
    logic [DW-1:0] rpl_data = '0;
    logic          irq;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] req_exp[$];
    logic [DW-1:0] rpl_exp[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hqp_top #(.DATA_W(DW), .REQ_DEPTH(DEPTH), .RPL_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
        .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: request entries taken by the controller must match the scoreboard (R1)
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            if (req_exp.size() == 0) begin
                check(1'b0, "R1 unexpected request", req_data, '0);
            end else begin
                logic [DW-1:0] e;
                e = req_exp.pop_front();
                check(req_data == e, "R1 request order", req_data, e);
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; bus_sel = 1'b0; req_ready = 1'b0; rpl_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        req_exp.delete();
        rpl_exp.delete();
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic req_post(input logic [DW-1:0] d, input bit accept);
        host_wr(2'd0, d);
        if (accept) req_exp.push_back(d);
    endtask

    task automatic ctrl_push(input logic [DW-1:0] d, output bit taken);
        @(posedge clk); #1;
        rpl_valid = 1'b1; rpl_data = d;
        @(negedge clk);
        taken = rpl_ready;
        @(posedge clk); #1;
        rpl_valid = 1'b0;
        if (taken) rpl_exp.push_back(d);
    endtask

    task automatic reply_take(input string tag);
        logic [DW-1:0] v;
        logic [DW-1:0] e;
        host_rd(2'd1, v);
        e = (rpl_exp.size() == 0) ? '1 : rpl_exp[0];
        check(v == e, tag, v, e);
        host_wr(2'd1, '0);
        if (rpl_exp.size() != 0) void'(rpl_exp.pop_front());
    endtask

    task automatic drain_req();
        req_ready = 1'b1;
        for (int i = 0; i < 4 * DEPTH && req_valid; i++) @(posedge clk);
        @(posedge clk); #1;
        req_ready = 1'b0;
        check(req_exp.size() == 0, "R1 scoreboard drained", DW'(req_exp.size()), '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        bit taken;
        do_reset();

        // R9: reset state
        host_rd(2'd0, v); check(v == 0, "R9 R2 request port after reset", v, 0);
        host_rd(2'd1, v); check(v == '1, "R9 R4 reply empty after reset", v, '1);
        host_rd(2'd2, v); check(v == 32'h8, "R9 mask after reset", v, 32'h8);
        host_rd(2'd3, v); check(v == 0, "R9 status after reset", v, 0);
        check(irq == 1'b0, "R9 irq after reset", DW'(irq), 0);

        // R1: a few requests in order
        req_post(32'h1000_0040, 1);
        req_post(32'h1000_0080, 1);
        req_post(32'h1000_00C0, 1);
        drain_req();

        // R2, R3: fill, overflow write dropped
        for (int i = 0; i < DEPTH; i++) req_post(32'hA000_0000 + i, 1);
        host_rd(2'd0, v); check(v == 1, "R2 full reads nonzero", v, 1);
        host_rd(2'd3, v); check(v[1] == 1'b0, "R3 no overflow yet", v, 0);
        req_post(32'hDEAD_0001, 0);
        host_rd(2'd3, v); check(v[1] == 1'b1, "R3 overflow sticky bit", v, 2);
        drain_req();
        host_rd(2'd0, v); check(v == 0, "R2 room after drain", v, 0);
        host_rd(2'd3, v); check(v[1] == 1'b1, "R3 overflow stays set", v, 2);

        // R3: full queue, pop and write in the same cycle -> write still dropped
        do_reset();
        for (int i = 0; i < DEPTH; i++) req_post(32'hB000_0000 + i, 1);
        @(posedge clk); #1;
        req_ready = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'hDEAD_0002;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; req_ready = 1'b0;
        host_rd(2'd3, v); check(v[1] == 1'b1, "R3 drop with same-cycle pop", v, 2);
        drain_req();

        // R10: request push and pop in one cycle with room
        req_post(32'hC000_0001, 1);
        @(posedge clk); #1;
        req_ready = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'hC000_0002;
        req_exp.push_back(32'hC000_0002);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; req_ready = 1'b0;
        check(req_valid == 1'b1 && req_data == 32'hC000_0002, "R10 request push+pop",
              req_data, 32'hC000_0002);
        drain_req();

        // R6, R4, R8: replies
        ctrl_push(32'h0000_0101, taken); check(taken, "R6 push accepted", DW'(taken), 1);
        ctrl_push(32'h0000_0202, taken);
        ctrl_push(32'h0000_0303, taken);
        host_rd(2'd1, v); check(v == 32'h101, "R4 peek head", v, 32'h101);
        host_rd(2'd1, v); check(v == 32'h101, "R4 peek does not pop", v, 32'h101);
        host_rd(2'd3, v); check(v[0] == 1'b1, "R8 pending while masked", v, 1);
        check(irq == 1'b0, "R7 irq masked", DW'(irq), 0);

        // R7: enable and disable
        host_wr(2'd2, 32'h0);
        host_rd(2'd2, v); check(v == 0, "R7 mask readback 0", v, 0);
        check(irq == 1'b1, "R8 irq with reply pending", DW'(irq), 1);
        host_wr(2'd2, 32'h8);
        check(irq == 1'b0, "R7 irq disabled again", DW'(irq), 0);
        host_wr(2'd2, 32'h0);

        // R5: nonzero write ignored
        host_wr(2'd1, 32'h5);
        host_rd(2'd1, v); check(v == 32'h101, "R5 nonzero write ignored", v, 32'h101);

        // R10: reply push and host pop in the same cycle
        @(posedge clk); #1;
        rpl_valid = 1'b1; rpl_data = 32'h0000_0404;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = '0;
        @(posedge clk); #1;
        rpl_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        void'(rpl_exp.pop_front());
        rpl_exp.push_back(32'h0000_0404);
        reply_take("R10 R5 reply after push+pop");
        reply_take("R10 R5 reply order 2");
        reply_take("R10 R5 reply order 3");
        host_rd(2'd1, v); check(v == '1, "R4 empty after pops", v, '1);
        check(irq == 1'b0, "R8 irq low when empty", DW'(irq), 0);

        // R5: zero write on empty ignored
        host_wr(2'd1, '0);
        ctrl_push(32'h0000_0505, taken);
        host_rd(2'd1, v); check(v == 32'h505, "R5 empty pop ignored", v, 32'h505);
        reply_take("R5 single reply");

        // R6: fill reply queue, ready drops
        for (int i = 0; i < DEPTH; i++) ctrl_push(32'hE000_0000 + i, taken);
        check(rpl_ready == 1'b0, "R6 ready low when full", DW'(rpl_ready), 0);
        ctrl_push(32'hDEAD_0003, taken);
        check(!taken, "R6 push refused when full", DW'(taken), 0);
        for (int i = 0; i < DEPTH; i++) reply_take("R6 reply order");
        host_rd(2'd3, v); check(v[0] == 1'b0, "R8 pending clear", v, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule